// File: doc/BRIEF.md
# Wide-Character Serial Transmitter

This block sends asynchronous serial frames whose character size can be 5, 6, 7, 8, 9, 13, 14, 15, 16 or 17 bits. The host assembles one character in three stages. A byte register holds bits 9 to 16, a one-bit register holds bit 17, and the low byte comes last. The write of the low byte commits all three parts as one character into a single-entry holding buffer. The buffer feeds a shift register, which puts a start bit, the data bits, an optional parity bit and one or two stop bits onto the line.

Bit timing comes from an external baud enable: the line changes only on clock edges where that enable is high, and each serial bit lasts from one enable to the next. Two flags report progress. The first shows that the holding buffer can take a new character. The second shows that every queued frame has left the line. Dropping the enable stops new characters from being accepted, but anything already in the buffer or the shifter still goes out in full.

Top module: `ext_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the stop bit(s) at 1. The line rests at 1 between frames. `txd` changes only on a clock edge where `baud_tick` is 1.
- R3: `len_sel` picks the data bit count: 0→5, 1→6, 2→7, 3→8, 4→9, 5→13, 6→14, 7→15, 8→16, 9→17. Any other value gives 8. Bits above the selected count are not sent.
- R4: `wr_ext` stores `wdata` as character bits 9–16, and `wr_b17` stores `wdata[0]` as bit 17. A later accepted `wr_lo` commits {bit17, ext byte, `wdata`} as one 17-bit character.
- R5: When `par_en` is 1, a parity bit follows the last data bit. It is the XOR of the sent data bits, inverted when `par_odd` is 1.
- R6: With `two_stop` at 1 there are two stop bits, otherwise one.
- R7: `buf_empty` is 1 exactly when the holding buffer is free. A `wr_lo` while the buffer is occupied is ignored and leaves the queued character unchanged.
- R8: An idle transmitter starts a buffered character on the next `baud_tick`. A buffered character starts on the tick that ends the current last stop bit, so consecutive frames have no idle gap.
- R9: `tx_done` becomes 1 on the tick that ends a frame when no character is waiting. It is cleared by an accepted `wr_lo`.
- R10: A `wr_lo` while `tx_en` is 0 is ignored. Clearing `tx_en` does not cut short the frame on the line or the character in the buffer: both are sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; gates acceptance of new characters |
| baud_tick | input | 1 | One-cycle baud enable; marks every bit boundary |
| len_sel | input | 4 | Character length code (see R3) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_ext | input | 1 | Write strobe for bits 9–16 |
| wr_b17 | input | 1 | Write strobe for bit 17 |
| wr_lo | input | 1 | Write strobe for the low byte; commits the character |
| wdata | input | 8 | Write data for all three strobes |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer free |
| tx_done | output | 1 | All queued frames have been sent |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse. They also assume that at most one of the three write strobes is high in a cycle, and that the length, parity and stop settings do not change while a character is in the buffer or on the line. These settings are read at the moment a character moves into the shifter. The stimulus raises the strobes one per cycle, changes the settings only after the model reports the line fully drained, and produces `baud_tick` from a free-running divider that pulses once every fourth cycle.

// File: rtl/ext_uart_pkg.sv
package ext_uart_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP1,
        PH_STOP2
    } phase_t;

    // Length code to data bit count; unknown codes fall back to eight bits.
    function automatic logic [4:0] len_decode(input logic [3:0] sel);
        logic [4:0] n;
        case (sel)
            4'd0:    n = 5'd5;
            4'd1:    n = 5'd6;
            4'd2:    n = 5'd7;
            4'd3:    n = 5'd8;
            4'd4:    n = 5'd9;
            4'd5:    n = 5'd13;
            4'd6:    n = 5'd14;
            4'd7:    n = 5'd15;
            4'd8:    n = 5'd16;
            4'd9:    n = 5'd17;
            default: n = 5'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ext_uart_txbuf.sv
module ext_uart_txbuf #(
    parameter  int BYTE_W = 8,
    localparam int DW     = 2 * BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_ext,
    input  logic              wr_b17,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DW-1:0]     hold_data,
    output logic              accept
);

    typedef struct packed {
        logic [BYTE_W-1:0] ext;
        logic              b17;
        logic              full;
        logic [DW-1:0]     hold;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        accept = wr_lo && tx_en && !q.full;
        if (wr_ext) d.ext = wdata;
        if (wr_b17) d.b17 = wdata[0];
        if (take)   d.full = 1'b0;
        if (accept) begin
            d.hold = {q.b17, q.ext, wdata};
            d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full      = q.full;
    assign hold_data = q.hold;

    // A queued character is never overwritten until the shifter takes it.
    p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !take) |=> ($stable(hold_data) && full));

endmodule

// File: rtl/ext_uart_txshift.sv
module ext_uart_txshift
    import ext_uart_pkg::*;
#(
    parameter  int DW = 17,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          ld_valid,
    input  logic [DW-1:0] ld_data,
    input  logic [3:0]    len_sel,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    output logic          ld_take,
    output logic          frame_done,
    output logic          txd
);

    typedef struct packed {
        phase_t        ph;
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [CW-1:0] nb;
        logic          par;
        logic          pen;
        logic          stop2;
    } st_t;

    st_t q, d;

    logic          load_c;
    logic          end_c;
    logic [CW-1:0] nb_c;
    logic [DW-1:0] mask_c;
    logic [DW-1:0] data_c;

    always_comb begin
        d      = q;
        load_c = 1'b0;
        end_c  = 1'b0;
        nb_c   = CW'(len_decode(len_sel));
        mask_c = DW'(({{DW{1'b0}}, 1'b1} << nb_c) - 1'b1);
        data_c = ld_data & mask_c;
        if (baud_tick) begin
            case (q.ph)
                PH_IDLE:  load_c = ld_valid;
                PH_START: begin
                    d.ph  = PH_DATA;
                    d.cnt = '0;
                end
                PH_DATA: begin
                    d.sh = q.sh >> 1;
                    if (q.cnt == q.nb - 1'b1) d.ph = q.pen ? PH_PAR : PH_STOP1;
                    else                      d.cnt = q.cnt + 1'b1;
                end
                PH_PAR:   d.ph = PH_STOP1;
                PH_STOP1: begin
                    if (q.stop2) d.ph = PH_STOP2;
                    else         end_c = 1'b1;
                end
                PH_STOP2: end_c = 1'b1;
                default:  d.ph = PH_IDLE;
            endcase
            if (end_c) begin
                if (ld_valid) load_c = 1'b1;
                else          d.ph = PH_IDLE;
            end
        end
        if (load_c) begin
            d.sh    = data_c;
            d.nb    = nb_c;
            d.par   = (^data_c) ^ par_odd;
            d.pen   = par_en;
            d.stop2 = two_stop;
            d.cnt   = '0;
            d.ph    = PH_START;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign ld_take    = load_c;
    assign frame_done = end_c && !ld_valid;

    always_comb begin
        case (q.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = q.sh[0];
            PH_PAR:   txd = q.par;
            default:  txd = 1'b1;
        endcase
    end

    // The line only moves on a baud enable.
    p_line_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    // Every character handed over opens with a low start bit.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_take |=> !txd);

    // An idle shifter waits for a tick before starting.
    p_idle_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !baud_tick) |=> (q.ph == PH_IDLE));

endmodule

// File: rtl/ext_uart_tx.sv
module ext_uart_tx #(
    parameter  int BYTE_W = 8,
    localparam int DW     = 2 * BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic [3:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              wr_ext,
    input  logic              wr_b17,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done
);

    logic          full;
    logic [DW-1:0] hold_data;
    logic          accept;
    logic          take;
    logic          frame_done;
    logic          done_d, done_q;

    ext_uart_txbuf #(.BYTE_W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .wr_ext   (wr_ext),
        .wr_b17   (wr_b17),
        .wr_lo    (wr_lo),
        .wdata    (wdata),
        .take     (take),
        .full     (full),
        .hold_data(hold_data),
        .accept   (accept)
    );

    ext_uart_txshift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .ld_valid  (full),
        .ld_data   (hold_data),
        .len_sel   (len_sel),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .two_stop  (two_stop),
        .ld_take   (take),
        .frame_done(frame_done),
        .txd       (txd)
    );

    always_comb begin
        done_d = done_q;
        if (frame_done) done_d = 1'b1;
        if (accept)     done_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_d;
    end

    assign tx_done   = done_q;
    assign buf_empty = !full;

    // A committed character always clears the completion flag.
    p_done_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!tx_done && !buf_empty));

    // Writes while disabled leave the buffer state as it was.
    p_disabled_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && buf_empty && !take) |=> buf_empty);

endmodule

// File: tb/sim_ext_uart_tx.sv
module sim_ext_uart_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic [3:0] len_sel = 4'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_ext = 1'b0;
    logic       wr_b17 = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       txd, buf_empty, tx_done;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    ext_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .wr_ext(wr_ext), .wr_b17(wr_b17),
        .wr_lo(wr_lo), .wdata(wdata), .txd(txd), .buf_empty(buf_empty),
        .tx_done(tx_done)
    );

    // ---------------- behavioural reference model ----------------
    int         lens [10] = '{5, 6, 7, 8, 9, 13, 14, 15, 16, 17};
    bit         mline[$];
    logic       mfull = 1'b0;
    logic       mdone = 1'b0;
    logic [16:0] mbuf = '0;
    logic [7:0] mext = '0;
    logic       mb17 = 1'b0;
    logic       m_oldfull;
    logic       m_ended;

    function automatic int bits_for(input logic [3:0] s);
        return (s <= 4'd9) ? lens[s] : 8;
    endfunction

    task automatic build_frame(input logic [16:0] v);
        int  n = bits_for(len_sel);
        bit  p = par_odd;
        mline.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            mline.push_back(v[i]);
            p ^= v[i];
        end
        if (par_en) mline.push_back(p);
        mline.push_back(1'b1);
        if (two_stop) mline.push_back(1'b1);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mline.delete();
            mfull = 1'b0;
            mdone = 1'b0;
            mext  = '0;
            mb17  = 1'b0;
        end else begin
            m_oldfull = mfull;
            m_ended   = 1'b0;
            if (baud_tick) begin
                if (mline.size() > 0) begin
                    void'(mline.pop_front());
                    if (mline.size() == 0) m_ended = 1'b1;
                end
                if (mline.size() == 0 && mfull) begin
                    build_frame(mbuf);
                    mfull = 1'b0;
                end else if (m_ended) begin
                    mdone = 1'b1;
                end
            end
            if (wr_lo && tx_en && !m_oldfull) begin
                mbuf  = {mb17, mext, wdata};
                mfull = 1'b1;
                mdone = 1'b0;
            end
            if (wr_ext) mext = wdata;
            if (wr_b17) mb17 = wdata[0];
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "txd", txd, (mline.size() > 0) ? mline[0] : 1'b1);
            chk(cur_req, "buf_empty", buf_empty, !mfull);
            chk(cur_req, "tx_done", tx_done, mdone);
        end
    end

    // baud enable: one cycle in four
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            baud_tick = (t == 3);
            t = (t + 1) % 4;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic put_char(input logic [7:0] ext, input logic b17, input logic [7:0] lo);
        @(negedge clk); wr_ext = 1'b1; wdata = ext;
        @(negedge clk); wr_ext = 1'b0; wr_b17 = 1'b1; wdata = {7'd0, b17};
        @(negedge clk); wr_b17 = 1'b0; wr_lo = 1'b1; wdata = lo;
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic wait_space();
        while (mfull) @(negedge clk);
    endtask

    task automatic wait_drain();
        while (mfull || mline.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values, checked before release
        chk("R1", "txd", txd, 1'b1);
        chk("R1", "buf_empty", buf_empty, 1'b1);
        chk("R1", "tx_done", tx_done, 1'b0);
        rst_n = 1'b1;
        tx_en = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3: every length code, plus an out-of-range code
        cur_req = "R3";
        for (int s = 0; s < 11; s++) begin
            len_sel = (s == 10) ? 4'd13 : s[3:0];
            put_char(8'hA5 ^ s[7:0], s[0], 8'h3C + s[7:0]);
            wait_drain();
            chk("R2", "tx_done after frame", tx_done, 1'b1);
        end

        // R4: seventeen bits with upper parts set
        cur_req = "R4";
        len_sel = 4'd9;
        put_char(8'h96, 1'b1, 8'h0F);
        wait_drain();
        put_char(8'h00, 1'b0, 8'hFF);
        wait_drain();

        // R5: parity even and odd at thirteen bits
        cur_req = "R5";
        len_sel = 4'd5;
        par_en  = 1'b1;
        for (int k = 0; k < 2; k++) begin
            par_odd = k[0];
            put_char(8'h1B, 1'b0, 8'hC7);
            wait_drain();
        end

        // R6: two stop bits
        cur_req = "R6";
        two_stop = 1'b1;
        len_sel  = 4'd1;
        put_char(8'h00, 1'b0, 8'h2A);
        wait_drain();
        par_en = 1'b0;
        two_stop = 1'b0;

        // R7 R8 R9: back-to-back frames and a write into a full buffer
        cur_req = "R8";
        len_sel = 4'd4;
        put_char(8'h01, 1'b0, 8'h55);
        wait_space();
        put_char(8'h00, 1'b0, 8'hAA);
        cur_req = "R7";
        @(negedge clk); wr_lo = 1'b1; wdata = 8'hE1;
        @(negedge clk); wr_lo = 1'b0;
        chk("R7", "buf_empty while occupied", buf_empty, 1'b0);
        cur_req = "R9";
        wait_drain();
        chk("R9", "tx_done set after last frame", tx_done, 1'b1);

        // R10: disable with a frame on the line and one buffered
        cur_req = "R10";
        put_char(8'h00, 1'b0, 8'h81);
        wait_space();
        put_char(8'h00, 1'b1, 8'h7E);
        tx_en = 1'b0;
        chk("R10", "buffer still held after disable", buf_empty, 1'b0);
        wait_drain();
        chk("R10", "tx_done after drain", tx_done, 1'b1);
        @(negedge clk); wr_lo = 1'b1; wdata = 8'h33;
        @(negedge clk); wr_lo = 1'b0;
        chk("R10", "write while disabled ignored", buf_empty, 1'b1);
        repeat (12) @(negedge clk);
        chk("R10", "line idle while disabled", txd, 1'b1);
        chk("R9", "tx_done kept after ignored write", tx_done, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule